// File: doc/BRIEF.md
# Johnson-Code PWM Lamp Dimmer Datapath

This block keeps the brightness of a lamp as a thermometer-style Johnson code and turns that code into a continuous pulse-width-modulated drive signal. The code has eight bits. A level of k has k ones packed from bit 0 upward, so the nine reachable codes give duty cycles from 0 % to 100 % in steps of 12.5 %. Each step request moves the level by one. The counter saturates at both ends and never wraps, so only nine of the sixteen Johnson states are ever used.

The whole block runs on the MUX clock, which is eight times the PWM frequency (for example 6.4 kHz for an 800 Hz lamp waveform). Step requests come in from a slower system clock domain as an enable strobe, `sys_tick`. The block synchronises this strobe and turns each of its rising edges into a single-cycle advance. The `step_up` and `step_dn` levels are assumed to be stable while the strobe is high. A free-running 3-bit down counter picks one code bit per MUX clock, and a register drives the selected bit out as the lamp signal. A control FSM or a button front end sits in front of this block.

Top module: `lamp_dimmer_core`

## Requirements
- R1: For every level k from 0 to 8, `lamp_pwm` is high for exactly k out of any 8 consecutive MUX clock cycles while the level is stable. The code always holds the form "k ones from bit 0 upward".
- R2: A low `rst_n` at a clock edge loads level 4 (code 00001111), drives `lamp_pwm` low, and clears `at_max` and `at_min`.
- R3: With `step_up` high and `step_dn` low, each rising edge of `sys_tick` raises the level by exactly one. Holding `sys_tick` high for several cycles still gives only one step.
- R4: With `step_dn` high and `step_up` low, each rising edge of `sys_tick` lowers the level by exactly one.
- R5: At level 8 (code 11111111) `at_max` is high. Further up steps leave the level at 8.
- R6: At level 0 (code 00000000) `at_min` is high. Further down steps leave the level at 0.
- R7: If `step_up` and `step_dn` are both high when a `sys_tick` edge arrives, the level does not change.
- R8: Changes on `step_up` or `step_dn` without a rising edge on `sys_tick` do not change the level.
- R9: The bit selector counts 7, 6, … 0 and then wraps back to 7. Reset loads 7. `lamp_pwm` shows the selected bit one clock later. So after reset at level 4, the eight output cycles that follow are 0,0,0,0,1,1,1,1.
- R10: When `sys_tick` is first sampled high at clock edge n, the new level and its flags appear after edge n+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | MUX clock, eight cycles per PWM period |
| rst_n | input | 1 | Synchronous active-low reset, loads half power |
| sys_tick | input | 1 | Step strobe from the slow system clock domain, asynchronous |
| step_up | input | 1 | Request one level brighter on the next strobe |
| step_dn | input | 1 | Request one level dimmer on the next strobe |
| lamp_pwm | output | 1 | Registered PWM drive for the lamp |
| at_max | output | 1 | High while the level is full brightness |
| at_min | output | 1 | High while the level is zero |

## Verification
The bench builds the block with its default parameters: an 8-bit code and a two-stage synchroniser. With these defaults the 3-bit selector and all nine levels are covered, and the duty cycle is measured at every level. The two-stage synchroniser fixes the edge-to-update latency at three clock edges, so the bench can check exactly when the flags change. It can also check that one long strobe gives one step, and that both ends saturate when pushed further.

// File: rtl/dimmer_pkg.sv
// Shared types for the lamp dimmer datapath.
// Assumes: nothing beyond IEEE 1800-2017.
package dimmer_pkg;

    // Decoded step request applied on a synchronised advance pulse
    typedef enum logic [1:0] {
        STEP_HOLD = 2'b00,
        STEP_UP   = 2'b01,
        STEP_DOWN = 2'b10
    } step_cmd_t;

endpackage

// File: rtl/dimmer_tick_sync.sv
// Brings the slow-domain step strobe into the MUX clock domain and
// emits a one-cycle pulse per rising edge.
// Assumes: strobe high and low times each exceed STAGES+1 clock cycles.
module dimmer_tick_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_async,
    output logic tick_pulse
);

    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Metastability chain followed by an edge-detect register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], tick_async};
            last_q <= sync_q[STAGES-1];
        end
    end

    // Rising edge of the synchronised strobe
    always_comb tick_pulse = sync_q[STAGES-1] & ~last_q;

    // R3: a held strobe yields a single advance pulse
    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_pulse |=> !tick_pulse);

endmodule

// File: rtl/dimmer_level_counter.sv
// Saturating Johnson (thermometer) brightness counter.
// Level k is held as k ones filled from bit 0 upward. Reset loads half
// power. Steps apply only on an advance pulse.
// Assumes: CODE_W is even and at least 2.
module dimmer_level_counter
    import dimmer_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  step_cmd_t         cmd,
    output logic [CODE_W-1:0] code_o,
    output logic              full_o,
    output logic              empty_o
);

    localparam logic [CODE_W-1:0] HALF_CODE = {{(CODE_W/2){1'b0}}, {(CODE_W/2){1'b1}}};

    logic [CODE_W-1:0] code_q;

    // Terminal-count status from the stored code
    always_comb begin
        full_o  = &code_q;
        empty_o = ~|code_q;
    end

    // Shift in a one (up) or a zero (down), inhibited at the ends
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= HALF_CODE;
        end else if (advance) begin
            unique case (cmd)
                STEP_UP:   if (!full_o)  code_q <= {code_q[CODE_W-2:0], 1'b1};
                STEP_DOWN: if (!empty_o) code_q <= {1'b0, code_q[CODE_W-1:1]};
                default:   code_q <= code_q;
            endcase
        end
    end

    assign code_o = code_q;

    // R2: reset loads the half-power code
    assert_reset_half_R2: assert property (@(posedge clk)
        !rst_n |=> code_q == HALF_CODE);

    // R1: stored code is always a low-filled thermometer
    assert_thermo_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q & (code_q + CODE_W'(1))) == '0);

    // R3: an up step adds exactly one level
    assert_step_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && cmd == STEP_UP && !full_o) |=> $countones(code_q) == $countones($past(code_q)) + 1);

    // R4: a down step removes exactly one level
    assert_step_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && cmd == STEP_DOWN && !empty_o) |=> $countones(code_q) + 1 == $countones($past(code_q)));

    // R5: no wrap past full brightness
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |=> (&code_q) || $countones(code_q) == CODE_W - 1);

    // R6: no wrap past zero
    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        empty_o |=> (~|code_q) || code_q == CODE_W'(1));

    // R7 / R8: no advance, or a hold command, keeps the level
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance || cmd == STEP_HOLD) |=> $stable(code_q));

endmodule

// File: rtl/dimmer_pwm_serializer.sv
// Serialises the brightness code onto the lamp output. A down counter
// selects bit CODE_W-1 first and wraps after bit 0. The output is
// registered so it cannot glitch.
// Assumes: code_i is a thermometer code in the same clock domain.
module dimmer_pwm_serializer #(
    parameter int CODE_W = 8,
    parameter int SEL_W  = $clog2(CODE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_i,
    output logic              pwm_o
);

    localparam logic [SEL_W-1:0] SEL_TOP = SEL_W'(CODE_W - 1);

    logic [SEL_W-1:0] sel_q;
    logic             pwm_q;

    // Free-running bit selector, counting down with wrap
    always_ff @(posedge clk) begin
        if (!rst_n)             sel_q <= SEL_TOP;
        else if (sel_q == '0)   sel_q <= SEL_TOP;
        else                    sel_q <= sel_q - SEL_W'(1);
    end

    // Registered multiplexer output
    always_ff @(posedge clk) begin
        if (!rst_n) pwm_q <= 1'b0;
        else        pwm_q <= code_i[sel_q];
    end

    assign pwm_o = pwm_q;

    // R9: selector wraps from 0 back to the top bit
    assert_sel_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sel_q == '0 |=> sel_q == SEL_TOP);

    // R9: selector otherwise decrements by one
    assert_sel_down_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sel_q != '0 |=> sel_q == $past(sel_q) - SEL_W'(1));

    // R2: output is low during reset
    assert_reset_low_R2: assert property (@(posedge clk)
        !rst_n |=> !pwm_q);

endmodule

// File: rtl/lamp_dimmer_core.sv
// Top of the dimmer datapath: strobe synchroniser, saturating Johnson
// level counter and PWM serialiser, all on the MUX clock.
// Assumes: step_up/step_dn are stable while sys_tick is high.
module lamp_dimmer_core
    import dimmer_pkg::*;
#(
    parameter int CODE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sys_tick,
    input  logic step_up,
    input  logic step_dn,
    output logic lamp_pwm,
    output logic at_max,
    output logic at_min
);

    localparam int SEL_W = $clog2(CODE_W);

    logic              advance;
    step_cmd_t         cmd;
    logic [CODE_W-1:0] level_code;

    // Decode the request levels; conflicting requests hold the level
    always_comb begin
        unique case ({step_dn, step_up})
            2'b01:   cmd = STEP_UP;
            2'b10:   cmd = STEP_DOWN;
            default: cmd = STEP_HOLD;
        endcase
    end

    dimmer_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_async (sys_tick),
        .tick_pulse (advance)
    );

    dimmer_level_counter #(.CODE_W(CODE_W)) u_level (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (advance),
        .cmd     (cmd),
        .code_o  (level_code),
        .full_o  (at_max),
        .empty_o (at_min)
    );

    dimmer_pwm_serializer #(.CODE_W(CODE_W), .SEL_W(SEL_W)) u_pwm (
        .clk    (clk),
        .rst_n  (rst_n),
        .code_i (level_code),
        .pwm_o  (lamp_pwm)
    );

    // R5 / R6: the flags are mutually exclusive
    assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(at_max && at_min));

endmodule

// File: tb/sim_lamp_dimmer_core.sv
module sim_lamp_dimmer_core;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sys_tick = 1'b0;
    logic step_up = 1'b0;
    logic step_dn = 1'b0;
    logic lamp_pwm, at_max, at_min;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    lamp_dimmer_core u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .sys_tick (sys_tick),
        .step_up  (step_up),
        .step_dn  (step_dn),
        .lamp_pwm (lamp_pwm),
        .at_max   (at_max),
        .at_min   (at_min)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One strobe held six cycles with the given request levels
    task automatic pulse_step(input logic up, input logic dn);
        @(negedge clk);
        step_up = up; step_dn = dn; sys_tick = 1'b1;
        repeat (6) @(negedge clk);
        sys_tick = 1'b0;
        repeat (4) @(negedge clk);
        step_up = 1'b0; step_dn = 1'b0;
    endtask

    // High cycles over one full 8-cycle window
    task automatic get_duty(output int k);
        k = 0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            k += int'(lamp_pwm);
        end
    endtask

    task automatic t_reset_and_order();
        logic [7:0] seq;
        int k;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R2 pwm in reset", int'(lamp_pwm), 0);
        check("R2 at_max in reset", int'(at_max), 0);
        check("R2 at_min in reset", int'(at_min), 0);
        rst_n = 1'b1;
        seq = '0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            seq = {seq[6:0], lamp_pwm};
        end
        check("R9 first period order", int'(seq), 8'b0000_1111);
        get_duty(k);
        check("R2 half duty after reset", k, 4);
    endtask

    task automatic t_up_to_seven();
        int k;
        for (int lvl = 5; lvl <= 7; lvl++) begin
            pulse_step(1'b1, 1'b0);
            get_duty(k);
            check($sformatf("R3 R1 single up step to %0d", lvl), k, lvl);
        end
        check("R5 at_max below top", int'(at_max), 0);
    endtask

    task automatic t_latency_to_max();
        int k;
        @(negedge clk);
        step_up = 1'b1; sys_tick = 1'b1;
        @(negedge clk);
        check("R10 no change after edge 1", int'(at_max), 0);
        @(negedge clk);
        check("R10 no change after edge 2", int'(at_max), 0);
        @(negedge clk);
        check("R10 at_max after edge 3", int'(at_max), 1);
        repeat (4) @(negedge clk);
        sys_tick = 1'b0;
        repeat (4) @(negedge clk);
        step_up = 1'b0;
        get_duty(k);
        check("R1 duty at level 8", k, 8);
    endtask

    task automatic t_saturate_max();
        int k;
        pulse_step(1'b1, 1'b0);
        get_duty(k);
        check("R5 up at max keeps level 8", k, 8);
        check("R5 at_max held", int'(at_max), 1);
    endtask

    task automatic t_down_to_zero();
        int k;
        for (int lvl = 7; lvl >= 0; lvl--) begin
            pulse_step(1'b0, 1'b1);
            get_duty(k);
            check($sformatf("R4 R1 down step to %0d", lvl), k, lvl);
        end
        check("R6 at_min at zero", int'(at_min), 1);
        check("R5 at_max clear at zero", int'(at_max), 0);
    endtask

    task automatic t_saturate_min();
        int k;
        pulse_step(1'b0, 1'b1);
        get_duty(k);
        check("R6 down at min keeps level 0", k, 0);
        check("R6 at_min held", int'(at_min), 1);
    endtask

    task automatic t_both_requests();
        int k;
        for (int i = 0; i < 3; i++) pulse_step(1'b1, 1'b0);
        get_duty(k);
        check("R3 climb to 3", k, 3);
        pulse_step(1'b1, 1'b1);
        get_duty(k);
        check("R7 both requests hold level", k, 3);
    endtask

    task automatic t_no_strobe();
        int k;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            step_up = i[0];
            step_dn = ~i[0];
        end
        @(negedge clk);
        step_up = 1'b0; step_dn = 1'b0;
        get_duty(k);
        check("R8 requests without strobe ignored", k, 3);
    endtask

    task automatic t_reset_midrun();
        int k;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        get_duty(k);
        check("R2 reset reloads half power", k, 4);
        check("R2 at_min cleared", int'(at_min), 0);
    endtask

    initial begin
        t_reset_and_order();
        t_up_to_seven();
        t_latency_to_max();
        t_saturate_max();
        t_down_to_zero();
        t_saturate_min();
        t_both_requests();
        t_no_strobe();
        t_reset_midrun();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule